// File: doc/BRIEF.md
# Parallel Laser Array Control Sequencer

This block decides, cycle by cycle, which of the channels of a parallel laser transmitter array may drive light. It watches an active-high enable, an active-high disable, an active-low control reset, a power-good indication and three one-bit fault sources: over-current, over-temperature and corrupted calibration data. From these it produces one drive-enable bit per channel and an active-low fault flag that holds its state once set. The analog drive circuits, current DACs, calibration memory and temperature sensing sit outside the block and reach it only through those status bits.

When the array is allowed to run, the channels turn on one at a time in ascending index order. A long settling wait comes before channel 0, and a fixed spacing separates each later channel from the one before it. The first start after power-good rises uses a longer wait than later restarts. A disable request must persist before it is obeyed, so short glitches on the enable pins are ignored. Faults shut the whole array and stay latched until the control reset is pulsed or power goes away. Every delay is a parameter counted in clock cycles, so the same logic runs at real time scales on silicon and at short scales in simulation. All control inputs are asynchronous and pass through two-flop synchronizers. The power-good input resets the block asynchronously and is released through its own synchronizer. The block has no data path, so every pin is a plain level signal and no handshake is involved.

Top module: `laser_array_seq`

## Requirements
- R1: While `pwr_good_i` is low, `drive_en_o` is all zeros and `fault_no` is 1. Both take these values at once when `pwr_good_i` falls, without waiting for a clock edge.
- R2: When `pwr_good_i` rises while `rst_ni`=1, `tx_on_i`=1, `tx_off_i`=0 and no fault input is high, bit 0 of `drive_en_o` rises PWR_WAIT_CYC+5 clock cycles after the edge on the pin. The power-up wait applies only to the first start after power-good rises.
- R3: After bit 0, bit k of `drive_en_o` rises STEP_CYC cycles after bit k-1, for k = 1 to NCH-1. While running, the set bits always form a contiguous run from bit 0, and no set bit clears until a shutdown.
- R4: A disable request exists when `tx_on_i` is 0 or `tx_off_i` is 1. Once the request has been held for DIS_QUAL_CYC consecutive clock cycles, all bits of `drive_en_o` clear, DIS_QUAL_CYC+3 cycles after the pin change. A request held for fewer cycles has no effect on `drive_en_o`.
- R5: When a qualified disable request is withdrawn, with no fault latched and `rst_ni`=1, bit 0 rises REEN_WAIT_CYC+4 cycles after the pin change, and the staggered order of R3 follows.
- R6: A high level on `ocur_i`, `otemp_i` or `calbad_i` while `rst_ni`=1 drives `fault_no` to 0 three cycles after the pin change. All bits of `drive_en_o` clear one cycle after that.
- R7: `fault_no` stays 0 after the fault input returns low, and the channels stay off. Only `rst_ni` low across at least one rising clock edge, or `pwr_good_i` low, clears the flag.
- R8: When `rst_ni` falls, `drive_en_o` clears and `fault_no` returns to 1, three cycles after the pin change. Fault inputs are ignored while reset is held. When `rst_ni` rises, bit 0 rises REEN_WAIT_CYC+3 cycles later, or PWR_WAIT_CYC+3 cycles later if this is the first start after power-good.
- R9: A fault, a qualified disable or a reset that arrives partway through a turn-on sequence clears every bit of `drive_en_o` in a single cycle. The next start begins again from channel 0 with the full wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| pwr_good_i | input | 1 | Supply good; low resets the block asynchronously, rise starts power-up |
| rst_ni | input | 1 | Control reset, active low; clears the fault flag and holds channels off |
| tx_on_i | input | 1 | Transmit enable, active high |
| tx_off_i | input | 1 | Transmit disable, active high |
| ocur_i | input | 1 | Over-current fault, active high |
| otemp_i | input | 1 | Over-temperature fault, active high |
| calbad_i | input | 1 | Calibration data corrupt, active high |
| drive_en_o | output | NCH | Per-channel drive enable, bit k for channel k |
| fault_no | output | 1 | Latched fault flag, active low |

## Verification
Some properties are checked on every cycle. The channel mask always forms a contiguous run from bit 0, grows by at most one bit per cycle, and never loses a bit while running. Any loss of the run condition empties the mask on the next cycle. The fault flag stays set until reset and is clear while reset is held. A disable is never obeyed before the request has lasted the qualification length, and the channels are off on the cycle after the flag falls. The exact cycle of each channel turn-on can only be shown by the bench's scenarios. So can the power-up wait versus the restart wait, glitch rejection, faults ignored under reset, and recovery after power loss.

// File: rtl/laser_seq_pkg.sv
package laser_seq_pkg;

  // Index of each control bit inside the synchronizer vector.
  localparam int CTL_W      = 6;
  localparam int CTL_ON     = 0;
  localparam int CTL_OFF    = 1;
  localparam int CTL_RSTN   = 2;
  localparam int CTL_OCUR   = 3;
  localparam int CTL_OTEMP  = 4;
  localparam int CTL_CALBAD = 5;

  // Values the synchronized controls show while the block is in power reset:
  // enable looks asserted so no disable request builds up, reset looks active.
  localparam logic [CTL_W-1:0] CTL_RST_VAL = 6'b000001;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_WAIT,
    SQ_RAMP,
    SQ_FULL
  } seq_st_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/lsc_pg_sync.sv
module lsc_pg_sync (
  input  logic clk_i,
  input  logic pg_i,
  output logic rst_no
);
  logic stg1, stg2;

  always_ff @(posedge clk_i or negedge pg_i) begin
    if (!pg_i) begin
      stg1 <= 1'b0;
      stg2 <= 1'b0;
    end else begin
      stg1 <= 1'b1;
      stg2 <= stg1;
    end
  end

  assign rst_no = stg2;
endmodule

// File: rtl/lsc_ctl_sync.sv
module lsc_ctl_sync #(
  parameter int               W       = 6,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic m1, m2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        m1 <= RST_VAL[i];
        m2 <= RST_VAL[i];
      end else begin
        m1 <= d_i[i];
        m2 <= m1;
      end
    end
    assign q_o[i] = m2;
  end
endmodule

// File: rtl/lsc_off_qual.sv
module lsc_off_qual #(
  parameter int QUAL_CYC = 250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic off_o
);
  localparam int QW = $clog2(QUAL_CYC + 1);
  localparam logic [QW-1:0] LAST = QW'(QUAL_CYC - 1);

  logic [QW-1:0] held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= '0;
      off_o  <= 1'b0;
    end else if (!req_i) begin
      held_q <= '0;
      off_o  <= 1'b0;
    end else if (held_q == LAST) begin
      off_o  <= 1'b1;
    end else begin
      held_q <= held_q + 1'b1;
    end
  end

  // Independent run-length counter for the check below.
  logic [QW:0] run_len;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        run_len <= '0;
    else if (!req_i)                    run_len <= '0;
    else if (run_len < (QW+1)'(QUAL_CYC)) run_len <= run_len + 1'b1;
  end

  // R4
  qual_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(off_o) |-> (run_len >= (QW+1)'(QUAL_CYC)));
endmodule

// File: rtl/lsc_fault_latch.sv
module lsc_fault_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctl_rst_ok_i,
  input  logic flt_any_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            flag_o <= 1'b0;
    else if (!ctl_rst_ok_i) flag_o <= 1'b0;
    else if (flt_any_i)     flag_o <= 1'b1;
  end

  // R7
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && ctl_rst_ok_i) |=> flag_o);

  // R8
  reset_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_rst_ok_i |=> !flag_o);
endmodule

// File: rtl/lsc_stagger.sv
module lsc_stagger
  import laser_seq_pkg::*;
#(
  parameter int NCH      = 12,
  parameter int PWR_WAIT = 15000000,
  parameter int REEN_WAIT = 13750000,
  parameter int STEP     = 1150000
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  output logic [NCH-1:0] drive_o
);
  localparam int MAXW = max3(PWR_WAIT, REEN_WAIT, STEP);
  localparam int CW   = $clog2(MAXW + 1);
  localparam int IW   = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [CW-1:0] PWR_M1  = CW'(PWR_WAIT - 1);
  localparam logic [CW-1:0] REEN_M1 = CW'(REEN_WAIT - 1);
  localparam logic [CW-1:0] STEP_M1 = CW'(STEP - 1);
  localparam logic [IW-1:0] IDX_TOP = IW'(NCH - 1);

  seq_st_e       st_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q;
  logic          boot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SQ_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      drive_o <= '0;
      boot_q  <= 1'b1;
    end else if (!run_i) begin
      st_q    <= SQ_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      drive_o <= '0;
    end else begin
      case (st_q)
        SQ_IDLE: begin
          cnt_q  <= boot_q ? PWR_M1 : REEN_M1;
          boot_q <= 1'b0;
          st_q   <= SQ_WAIT;
        end
        SQ_WAIT: begin
          if (cnt_q == '0) begin
            drive_o[0] <= 1'b1;
            idx_q      <= IW'(1);
            cnt_q      <= STEP_M1;
            st_q       <= (NCH > 1) ? SQ_RAMP : SQ_FULL;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        SQ_RAMP: begin
          if (cnt_q == '0) begin
            drive_o[idx_q] <= 1'b1;
            cnt_q          <= STEP_M1;
            if (idx_q == IDX_TOP) st_q  <= SQ_FULL;
            else                  idx_q <= idx_q + 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R9
  abort_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (drive_o == '0));

  // R3
  contiguous_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((drive_o & (drive_o + 1'b1)) == '0));

  // R3
  one_at_a_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> ($countones(drive_o) <= $countones($past(drive_o)) + 1));

  // R3
  no_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> ((drive_o & $past(drive_o)) == $past(drive_o)));
endmodule

// File: rtl/laser_array_seq.sv
module laser_array_seq
  import laser_seq_pkg::*;
#(
  parameter int NCH           = 12,
  parameter int PWR_WAIT_CYC  = 15000000,
  parameter int REEN_WAIT_CYC = 13750000,
  parameter int STEP_CYC      = 1150000,
  parameter int DIS_QUAL_CYC  = 250000
) (
  input  logic           clk_i,
  input  logic           pwr_good_i,
  input  logic           rst_ni,
  input  logic           tx_on_i,
  input  logic           tx_off_i,
  input  logic           ocur_i,
  input  logic           otemp_i,
  input  logic           calbad_i,
  output logic [NCH-1:0] drive_en_o,
  output logic           fault_no
);
  logic             pg_rst_n;
  logic [CTL_W-1:0] ctl_raw, ctl_s;
  logic             dis_req, off_q, flt_q, flt_any, run;

  lsc_pg_sync u_pg_sync (
    .clk_i  (clk_i),
    .pg_i   (pwr_good_i),
    .rst_no (pg_rst_n)
  );

  always_comb begin
    ctl_raw             = '0;
    ctl_raw[CTL_ON]     = tx_on_i;
    ctl_raw[CTL_OFF]    = tx_off_i;
    ctl_raw[CTL_RSTN]   = rst_ni;
    ctl_raw[CTL_OCUR]   = ocur_i;
    ctl_raw[CTL_OTEMP]  = otemp_i;
    ctl_raw[CTL_CALBAD] = calbad_i;
  end

  lsc_ctl_sync #(.W(CTL_W), .RST_VAL(CTL_RST_VAL)) u_ctl_sync (
    .clk_i  (clk_i),
    .rst_ni (pg_rst_n),
    .d_i    (ctl_raw),
    .q_o    (ctl_s)
  );

  assign dis_req = !ctl_s[CTL_ON] || ctl_s[CTL_OFF];
  assign flt_any = ctl_s[CTL_OCUR] || ctl_s[CTL_OTEMP] || ctl_s[CTL_CALBAD];

  lsc_off_qual #(.QUAL_CYC(DIS_QUAL_CYC)) u_off_qual (
    .clk_i  (clk_i),
    .rst_ni (pg_rst_n),
    .req_i  (dis_req),
    .off_o  (off_q)
  );

  lsc_fault_latch u_fault (
    .clk_i        (clk_i),
    .rst_ni       (pg_rst_n),
    .ctl_rst_ok_i (ctl_s[CTL_RSTN]),
    .flt_any_i    (flt_any),
    .flag_o       (flt_q)
  );

  assign run = ctl_s[CTL_RSTN] && !off_q && !flt_q;

  lsc_stagger #(
    .NCH       (NCH),
    .PWR_WAIT  (PWR_WAIT_CYC),
    .REEN_WAIT (REEN_WAIT_CYC),
    .STEP      (STEP_CYC)
  ) u_stagger (
    .clk_i   (clk_i),
    .rst_ni  (pg_rst_n),
    .run_i   (run),
    .drive_o (drive_en_o)
  );

  assign fault_no = !flt_q;

  // R6
  fault_dark_chk: assert property (@(posedge clk_i) disable iff (!pg_rst_n)
    !fault_no |=> (drive_en_o == '0));
endmodule

// File: tb/laser_array_seq_tb_top.sv
module laser_array_seq_tb_top;
  localparam int NCH = 12;
  localparam int PW  = 60;
  localparam int RW  = 55;
  localparam int ST  = 5;
  localparam int QL  = 10;
  localparam int BIG = 32'h3fffffff;
  localparam logic [NCH-1:0] FULL = '1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic pwr_good = 1'b0, rst_n = 1'b1, tx_on = 1'b1, tx_off = 1'b0;
  logic ocur = 1'b0, otemp = 1'b0, calbad = 1'b0;
  logic [NCH-1:0] drive;
  logic fault_n;

  laser_array_seq #(
    .NCH(NCH), .PWR_WAIT_CYC(PW), .REEN_WAIT_CYC(RW),
    .STEP_CYC(ST), .DIS_QUAL_CYC(QL)
  ) dut_i (
    .clk_i(clk), .pwr_good_i(pwr_good), .rst_ni(rst_n),
    .tx_on_i(tx_on), .tx_off_i(tx_off),
    .ocur_i(ocur), .otemp_i(otemp), .calbad_i(calbad),
    .drive_en_o(drive), .fault_no(fault_n)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;

  typedef struct {
    int             at;
    logic [NCH-1:0] m;
    logic           f;
    string          tag;
  } ev_t;
  ev_t sb[$];

  task automatic chk(input bit ok, input string tag, input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  task automatic expect_ev(input int at, input logic [NCH-1:0] m, input logic f, input string tag);
    ev_t e;
    e.at = at; e.m = m; e.f = f; e.tag = tag;
    sb.push_back(e);
  endtask

  // Cumulative turn-on events from c0, only those before limit.
  task automatic expect_ramp(input int c0, input int limit, input string tag);
    logic [NCH-1:0] m;
    m = '0;
    for (int k = 0; k < NCH; k++) begin
      m[k] = 1'b1;
      if (c0 + k*ST < limit) expect_ev(c0 + k*ST, m, 1'b1, tag);
    end
  endtask

  task automatic at_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic drain(input string tag);
    int lim;
    lim = cyc + 3000;
    while (sb.size() > 0 && cyc < lim) @(negedge clk);
    chk(sb.size() == 0, tag, $sformatf("%0d expected changes missing (actual 0 pending expected)", sb.size()));
    sb.delete();
  endtask

  // Monitor: every change of the outputs pops and compares one expected item.
  initial begin
    logic [NCH:0] prev, cur;
    prev = {{NCH{1'b0}}, 1'b1};
    forever begin
      @(negedge clk);
      #1;
      cur = {drive, fault_n};
      if (cur !== prev) begin
        if (sb.size() == 0) begin
          chk(1'b0, "SB", $sformatf("unexpected change cyc %0d drive %h fault_n %b, expected no change",
                                     cyc, drive, fault_n));
        end else begin
          ev_t e;
          e = sb.pop_front();
          chk(cyc == e.at && drive === e.m && fault_n === e.f, e.tag,
              $sformatf("cyc %0d/%0d drive %h/%h fault_n %b/%b (actual/expected)",
                        cyc, e.at, drive, e.m, fault_n, e.f));
        end
        prev = cur;
      end
    end
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    int t, c0, a;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state with power-good low
    chk(drive == '0 && fault_n == 1'b1, "R1",
        $sformatf("power-off state drive %h fault_n %b, expected 0/1", drive, fault_n));

    // R2 / R3 power-up staggered turn-on
    @(negedge clk);
    pwr_good = 1'b1; t = cyc;
    expect_ramp(t + 5 + PW, BIG, "R2_R3");
    drain("R2");
    chk(drive == FULL, "R3", $sformatf("all channels on: drive %h expected %h", drive, FULL));

    // R4 short disable glitch is ignored
    at_cyc(cyc + 3);
    tx_off = 1'b1; t = cyc;
    at_cyc(t + QL - 3);
    tx_off = 1'b0;
    at_cyc(cyc + 25);
    chk(drive == FULL && sb.size() == 0, "R4",
        $sformatf("glitch ignored: drive %h expected %h", drive, FULL));

    // R4 qualified disable via disable pin, R5 re-enable with restart wait
    at_cyc(cyc + 2);
    tx_off = 1'b1; t = cyc;
    expect_ev(t + 3 + QL, '0, 1'b1, "R4");
    drain("R4");
    at_cyc(cyc + 5);
    tx_off = 1'b0; t = cyc;
    expect_ramp(t + 4 + RW, BIG, "R5");
    drain("R5");

    // R4 via enable pin low, R9 abort of re-enable sequence by disable
    at_cyc(cyc + 2);
    tx_on = 1'b0; t = cyc;
    expect_ev(t + 3 + QL, '0, 1'b1, "R4");
    drain("R4");
    at_cyc(cyc + 5);
    tx_on = 1'b1; t = cyc;
    c0 = t + 4 + RW;
    a  = c0 + 2*ST + 1;
    expect_ramp(c0, a + 3 + QL, "R9");
    expect_ev(a + 3 + QL, '0, 1'b1, "R9");
    at_cyc(a);
    tx_on = 1'b0;
    drain("R9");
    at_cyc(cyc + 3);
    tx_on = 1'b1; t = cyc;
    expect_ramp(t + 4 + RW, BIG, "R9");
    drain("R9");

    // R6 over-current fault, R7 latched after source drops
    at_cyc(cyc + 3);
    ocur = 1'b1; t = cyc;
    expect_ev(t + 3, FULL, 1'b0, "R6");
    expect_ev(t + 4, '0, 1'b0, "R6");
    at_cyc(t + 2);
    ocur = 1'b0;
    drain("R6");
    at_cyc(cyc + 30);
    chk(drive == '0 && fault_n == 1'b0, "R7",
        $sformatf("fault held: drive %h fault_n %b, expected 0/0", drive, fault_n));

    // R7 reset pulse clears flag; R9 reset aborts the restart; R8 restart after reset
    at_cyc(cyc + 2);
    rst_n = 1'b0; t = cyc;
    expect_ev(t + 3, '0, 1'b1, "R7");
    at_cyc(t + 2);
    rst_n = 1'b1;
    c0 = t + 5 + RW;
    a  = c0 + ST + 1;
    expect_ramp(c0, a + 3, "R8");
    expect_ev(a + 3, '0, 1'b1, "R9");
    at_cyc(a);
    rst_n = 1'b0;
    at_cyc(a + 6);
    rst_n = 1'b1;
    expect_ramp(a + 9 + RW, BIG, "R8");
    drain("R8");

    // R8 reset shuts down, fault ignored while reset held
    at_cyc(cyc + 2);
    rst_n = 1'b0; t = cyc;
    expect_ev(t + 3, '0, 1'b1, "R8");
    at_cyc(t + 5);
    otemp = 1'b1;
    at_cyc(t + 9);
    otemp = 1'b0;
    at_cyc(t + 20);
    chk(fault_n == 1'b1 && drive == '0, "R8",
        $sformatf("fault under reset: fault_n %b drive %h, expected 1/0", fault_n, drive));
    drain("R8");

    // R6/R9 calibration fault during the wait phase
    at_cyc(t + 22);
    rst_n = 1'b1;
    at_cyc(t + 30);
    calbad = 1'b1;
    expect_ev(t + 33, '0, 1'b0, "R6");
    at_cyc(t + 33);
    calbad = 1'b0;
    drain("R6");

    // R1 power loss clears latched fault; R2 power-up wait applies again
    at_cyc(cyc + 10);
    chk(fault_n == 1'b0, "R7", $sformatf("fault kept: fault_n %b expected 0", fault_n));
    pwr_good = 1'b0; t = cyc;
    expect_ev(t, '0, 1'b1, "R1");
    at_cyc(t + 5);
    pwr_good = 1'b1;
    expect_ramp(t + 10 + PW, BIG, "R2");
    drain("R2");

    // R1 power loss with all channels on
    at_cyc(cyc + 3);
    pwr_good = 1'b0; t = cyc;
    expect_ev(t, '0, 1'b1, "R1");
    drain("R1");
    at_cyc(cyc + 5);

    summary();
    $finish;
  end
endmodule